// File: doc/BRIEF.md
# Configurable Chainable Dual Timer

This block is a timer peripheral built on a pair of free-running up-counting halves, each `HALF_W` bits wide. Software picks one of three modes. In full mode the halves form one double-width counter. In chained mode the low half acts as a prescaler whose wraps advance the high half. In independent mode the two halves run side by side, each from the clock. Each half has a period register. When a count reaches its period, the count returns to zero and a one-cycle interrupt is raised.

Up to eight compare channels watch the low half. Each channel has its own value register and enable bit, and raises its own one-cycle interrupt. The `CMP_PRESENT` parameter removes any channel from the hardware. A simple single-cycle register port handles configuration. Reading the low count captures the high count at the same moment, so software can assemble a coherent double-width value. `HALF_W` must be at least 8, and `CMP_NUM` may be at most 8.

Top module: `chain_timer`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low. The register addresses are: 0 control, 1 low count, 2 high count, 3 low period, 4 high period, 5 compare enables (bit i for channel i), and 8+i compare value i.
- R2: In full mode (control bits [1:0] = 0, low run bit = control bit 2), the count {high,low} advances by one per running cycle, with carry from low into high. On the edge where the count equals {high period, low period}, the count reloads to zero and `irq_lo` is high for that next cycle. `irq_hi` stays low.
- R3: In chained mode (control bits [1:0] = 1), the low half counts running cycles and wraps to zero after showing its period. Each wrap adds one to the high half when the high run bit (control bit 3) is set. The high half wraps after showing its own period at a low-half wrap, and that event pulses `irq_hi`. `irq_lo` stays low.
- R4: In independent mode (control bits [1:0] = 2 or 3), each half counts the clock under its own run bit, wraps to zero at its own period, and pulses its own interrupt for one cycle.
- R5: A half whose run bit is clear holds its count. In full mode the high run bit has no effect.
- R6: A control write whose mode differs from the current mode (with 2 and 3 treated as the same mode) clears both counts to zero. A control write that keeps the mode leaves both counts unchanged.
- R7: An enabled compare channel i pulses `irq_cmp[i]` for one cycle after a running cycle in which the low count equals its value register.
- R8: A disabled channel, or a channel removed through `CMP_PRESENT`, never raises its interrupt.
- R9: A read of the low count captures the high count. Later reads of address 2 return that captured value.
- R10: Writes to addresses 1 and 2 load the low and high counts directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures high count on a low-count read) |
| addr | input | 4 | Register address |
| wdata | input | HALF_W | Write data |
| rdata | output | HALF_W | Read data, combinational from addr |
| irq_lo | output | 1 | Low-half / full-mode period interrupt |
| irq_hi | output | 1 | High-half period interrupt |
| irq_cmp | output | CMP_NUM | Compare channel interrupts |

## Verification
The hardest situations to reach are the carry from the low word into the high word, and a capture that stays coherent while the count is crossing that carry. Without help, either would take 2^HALF_W cycles. The bench uses an 8-bit half, so every full wrap is reachable in a few hundred cycles. It also preloads the counts through the counter registers, then reads the low word one cycle before a carry and the high word after it. Mode and period sweeps compare the final counts and interrupt tallies against closed-form quotient and remainder results.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_CHAIN = 2'd1,
    MODE_SPLIT = 2'd2
  } tmode_e;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_CNT_LO = 4'd1;
  localparam logic [3:0] A_CNT_HI = 4'd2;
  localparam logic [3:0] A_PRD_LO = 4'd3;
  localparam logic [3:0] A_PRD_HI = 4'd4;
  localparam logic [3:0] A_CMP_EN = 4'd5;

  localparam int CTRL_W     = 4;
  localparam int RUN_LO_BIT = 2;
  localparam int RUN_HI_BIT = 3;

  // field value 3 behaves as independent mode
  function automatic tmode_e decode_mode(input logic [1:0] f);
    case (f)
      2'd0:    return MODE_FULL;
      2'd1:    return MODE_CHAIN;
      default: return MODE_SPLIT;
    endcase
  endfunction

endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import chain_timer_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [3:0]          addr,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        rdata,
  input  logic [W-1:0]        cnt_lo,
  input  logic [W-1:0]        cnt_hi,
  output tmode_e              mode,
  output logic                run_lo,
  output logic                run_hi,
  output logic [W-1:0]        prd_lo,
  output logic [W-1:0]        prd_hi,
  output logic [N-1:0][W-1:0] cmp_val,
  output logic [N-1:0]        cmp_en,
  output logic                wr_lo,
  output logic                wr_hi,
  output logic                mode_clr
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      hi_snap;
  logic              ctrl_wr;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign mode     = decode_mode(ctrl_q[1:0]);
  assign run_lo   = ctrl_q[RUN_LO_BIT];
  assign run_hi   = ctrl_q[RUN_HI_BIT];
  assign mode_clr = ctrl_wr && (decode_mode(wdata[1:0]) != mode);
  assign wr_lo    = wr_en && (addr == A_CNT_LO);
  assign wr_hi    = wr_en && (addr == A_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      prd_lo  <= '0;
      prd_hi  <= '0;
      cmp_en  <= '0;
      cmp_val <= '0;
      hi_snap <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && addr == A_PRD_LO) prd_lo <= wdata;
      if (wr_en && addr == A_PRD_HI) prd_hi <= wdata;
      if (wr_en && addr == A_CMP_EN) cmp_en <= wdata[N-1:0];
      for (int i = 0; i < N; i++) begin
        if (wr_en && addr[3] && addr[2:0] == 3'(i)) cmp_val[i] <= wdata;
      end
      if (rd_en && addr == A_CNT_LO) hi_snap <= cnt_hi;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_CNT_LO: rdata = cnt_lo;
      A_CNT_HI: rdata = hi_snap;
      A_PRD_LO: rdata = prd_lo;
      A_PRD_HI: rdata = prd_hi;
      A_CMP_EN: rdata[N-1:0] = cmp_en;
      default: begin
        for (int i = 0; i < N; i++) begin
          if (addr[3] && addr[2:0] == 3'(i)) rdata = cmp_val[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/ct_core.sv
module ct_core
  import chain_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmode_e       mode,
  input  logic         run_lo,
  input  logic         run_hi,
  input  logic         mode_clr,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] prd_lo,
  input  logic [W-1:0] prd_hi,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         lo_tick,
  output logic         ev_lo_wrap,
  output logic         irq_lo,
  output logic         irq_hi
);

  localparam int FW = 2 * W;

  function automatic logic [W-1:0] step_half(input logic [W-1:0] c, input logic [W-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [FW-1:0] step_full(input logic [FW-1:0] c, input logic [FW-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  logic hi_tick;
  logic ev_hi_wrap;
  logic ev_full_wrap;

  always_comb begin
    lo_tick      = run_lo;
    ev_full_wrap = (mode == MODE_FULL) && run_lo && ({cnt_hi, cnt_lo} == {prd_hi, prd_lo});
    ev_lo_wrap   = (mode != MODE_FULL) && run_lo && (cnt_lo == prd_lo);
    case (mode)
      MODE_FULL:  hi_tick = 1'b0;
      MODE_CHAIN: hi_tick = run_hi && ev_lo_wrap;
      default:    hi_tick = run_hi;
    endcase
    ev_hi_wrap = hi_tick && (cnt_hi == prd_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else if (mode_clr) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= ev_full_wrap || ((mode == MODE_SPLIT) && ev_lo_wrap);
      irq_hi <= ev_hi_wrap;
      if (mode == MODE_FULL) begin
        if (run_lo) {cnt_hi, cnt_lo} <= step_full({cnt_hi, cnt_lo}, {prd_hi, prd_lo});
      end else begin
        if (run_lo)  cnt_lo <= step_half(cnt_lo, prd_lo);
        if (hi_tick) cnt_hi <= step_half(cnt_hi, prd_hi);
      end
      if (wr_lo) cnt_lo <= wdata;
      if (wr_hi) cnt_hi <= wdata;
    end
  end

endmodule

// File: rtl/ct_cmp.sv
module ct_cmp #(
  parameter int         W       = 32,
  parameter int         N       = 8,
  parameter logic [7:0] PRESENT = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        cnt_lo,
  input  logic                lo_tick,
  input  logic [N-1:0][W-1:0] cmp_val,
  input  logic [N-1:0]        cmp_en,
  output logic [N-1:0]        irq_cmp
);

  function automatic logic cmp_hit(input logic [W-1:0] c, input logic [W-1:0] v,
                                   input logic en, input logic tick);
    return en && tick && (c == v);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_ch
    if (PRESENT[g]) begin : g_on
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= cmp_hit(cnt_lo, cmp_val[g], cmp_en[g], lo_tick);
      end
      assign irq_cmp[g] = pulse_q;
    end else begin : g_off
      assign irq_cmp[g] = 1'b0;
    end
  end

endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import chain_timer_pkg::*;
#(
  parameter int         HALF_W      = 32,
  parameter int         CMP_NUM     = 8,
  parameter logic [7:0] CMP_PRESENT = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [HALF_W-1:0]  wdata,
  output logic [HALF_W-1:0]  rdata,
  output logic               irq_lo,
  output logic               irq_hi,
  output logic [CMP_NUM-1:0] irq_cmp
);

  tmode_e                          mode;
  logic                            run_lo;
  logic                            run_hi;
  logic [HALF_W-1:0]               prd_lo;
  logic [HALF_W-1:0]               prd_hi;
  logic [CMP_NUM-1:0][HALF_W-1:0]  cmp_val;
  logic [CMP_NUM-1:0]              cmp_en;
  logic                            wr_lo;
  logic                            wr_hi;
  logic                            mode_clr;
  logic [HALF_W-1:0]               cnt_lo;
  logic [HALF_W-1:0]               cnt_hi;
  logic                            lo_tick;
  logic                            ev_lo_wrap;

  ct_regs #(.W(HALF_W), .N(CMP_NUM)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .mode(mode), .run_lo(run_lo), .run_hi(run_hi), .prd_lo(prd_lo), .prd_hi(prd_hi),
    .cmp_val(cmp_val), .cmp_en(cmp_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .mode_clr(mode_clr)
  );

  ct_core #(.W(HALF_W)) core_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run_lo(run_lo), .run_hi(run_hi),
    .mode_clr(mode_clr), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
    .prd_lo(prd_lo), .prd_hi(prd_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .lo_tick(lo_tick), .ev_lo_wrap(ev_lo_wrap), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  ct_cmp #(.W(HALF_W), .N(CMP_NUM), .PRESENT(CMP_PRESENT)) cmp_i (
    .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .lo_tick(lo_tick),
    .cmp_val(cmp_val), .cmp_en(cmp_en), .irq_cmp(irq_cmp)
  );

endmodule

// File: rtl/chain_timer_chk.sv
module chain_timer_chk
  import chain_timer_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input tmode_e       mode,
  input logic         run_lo,
  input logic         cnt_wr,
  input logic         mode_clr,
  input logic         ev_lo_wrap,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic [N-1:0] irq_cmp,
  input logic [N-1:0] cmp_en
);

  assert_full_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && $past(mode) == MODE_FULL && !$past(cnt_wr)) |-> (cnt_lo == '0 && cnt_hi == '0));

  assert_full_hi_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> $past(mode) != MODE_FULL);

  assert_chain_lo_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> $past(mode) != MODE_CHAIN);

  assert_chain_hi_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_CHAIN && !$past(cnt_wr) && !$past(mode_clr) && cnt_hi != $past(cnt_hi))
      |-> $past(ev_lo_wrap));

  assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_lo) && !$past(cnt_wr) && !$past(mode_clr)) |-> cnt_lo == $past(cnt_lo));

  assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (cnt_lo == '0 && cnt_hi == '0));

  assert_cmp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp & ~$past(cmp_en)) == '0);

endmodule

bind chain_timer chain_timer_chk #(.W(HALF_W), .N(CMP_NUM)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .run_lo(run_lo), .cnt_wr(wr_lo | wr_hi),
  .mode_clr(mode_clr), .ev_lo_wrap(ev_lo_wrap), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp), .cmp_en(cmp_en)
);

// File: tb/chain_timer_tb_top.sv
`timescale 1ns/1ps
module chain_timer_tb_top;
  import chain_timer_pkg::*;

  localparam int         W    = 8;
  localparam int         N    = 4;
  localparam logic [7:0] PRES = 8'h07;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq_lo;
  logic         irq_hi;
  logic [N-1:0] irq_cmp;

  int n_run = 0;
  int n_fail = 0;
  int c_lo = 0;
  int c_hi = 0;
  int c_cmp [N];

  always #2.5 clk = ~clk;

  chain_timer #(.HALF_W(W), .CMP_NUM(N), .CMP_PRESENT(PRES)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_lo) c_lo++;
      if (irq_hi) c_hi++;
      for (int i = 0; i < N; i++) if (irq_cmp[i]) c_cmp[i]++;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, int d);
    addr = a; wdata = d[W-1:0]; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    addr = a; rd_en = 1'b1;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_mon();
    c_lo = 0; c_hi = 0;
    for (int i = 0; i < N; i++) c_cmp[i] = 0;
  endtask

  task automatic setup(int md, int plo, int phi);
    wr(A_CTRL, md);
    wr(A_CNT_LO, 0);
    wr(A_CNT_HI, 0);
    wr(A_PRD_LO, plo);
    wr(A_PRD_HI, phi);
    clear_mon();
  endtask

  // exactly n counting edges, then a settle window for the last pulse
  task automatic run(int ctrl, int n);
    wr(A_CTRL, ctrl);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, ctrl & 3);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_pair(output int lo, output int hi);
    rd(A_CNT_LO, lo);
    rd(A_CNT_HI, hi);
  endtask

  function automatic int cmp_hits(int v, int n, int per);
    return (v < n) ? ((n - 1 - v) / per + 1) : 0;
  endfunction

  initial begin
    int lo, hi, v, p, e, w;
    int full_p [4]  = '{5, 259, 767, 0};
    int ch_lo [4]   = '{3, 9, 0, 6};
    int ch_hi [4]   = '{4, 0, 2, 255};
    int sp_lo [4]   = '{4, 10, 0, 200};
    int sp_hi [4]   = '{7, 0, 3, 99};
    logic [3:0] regs [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd11};

    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (regs[k]) begin
      rd(regs[k], v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset irqs", int'(irq_lo | irq_hi | (|irq_cmp)), 0);

    // R2: full mode sweep over periods
    foreach (full_p[k]) begin
      p = full_p[k];
      setup(0, p & 255, p >> 8);
      run(4, 700);
      read_pair(lo, hi);
      e = 700 % (p + 1);
      check("R2 full low count", lo, e & 255);
      check("R2 full high count", hi, e >> 8);
      check("R2 full irq_lo pulses", c_lo, 700 / (p + 1));
      check("R2 full irq_hi quiet", c_hi, 0);
    end

    // R5: full mode ignores high run bit
    setup(0, 9, 0);
    run(8, 50);
    read_pair(lo, hi);
    check("R5 full high-run only low", lo, 0);
    check("R5 full high-run only high", hi, 0);
    check("R5 full high-run only irq", c_lo, 0);

    // R3: chained sweep
    foreach (ch_lo[k]) begin
      setup(1, ch_lo[k], ch_hi[k]);
      run(13, 500);
      read_pair(lo, hi);
      w = 500 / (ch_lo[k] + 1);
      check("R3 chain low count", lo, 500 % (ch_lo[k] + 1));
      check("R3 chain high count", hi, w % (ch_hi[k] + 1));
      check("R3 chain irq_hi pulses", c_hi, w / (ch_hi[k] + 1));
      check("R3 chain irq_lo quiet", c_lo, 0);
    end

    // R4: independent sweep
    foreach (sp_lo[k]) begin
      setup(2, sp_lo[k], sp_hi[k]);
      run(14, 300);
      read_pair(lo, hi);
      check("R4 split low count", lo, 300 % (sp_lo[k] + 1));
      check("R4 split high count", hi, 300 % (sp_hi[k] + 1));
      check("R4 split irq_lo pulses", c_lo, 300 / (sp_lo[k] + 1));
      check("R4 split irq_hi pulses", c_hi, 300 / (sp_hi[k] + 1));
    end

    // R5: independent, only low runs
    setup(2, 4, 4);
    run(6, 23);
    read_pair(lo, hi);
    check("R5 split low runs", lo, 3);
    check("R5 split high held", hi, 0);
    check("R5 split irq_hi quiet", c_hi, 0);
    check("R5 split irq_lo pulses", c_lo, 4);

    // R6 / R10: mode change clears, same mode keeps, counter writes load
    wr(A_CTRL, 1);
    read_pair(lo, hi);
    check("R6 mode change clears low", lo, 0);
    check("R6 mode change clears high", hi, 0);
    wr(A_CNT_LO, 5);
    wr(A_CNT_HI, 7);
    read_pair(lo, hi);
    check("R10 low load", lo, 5);
    check("R10 high load", hi, 7);
    wr(A_CTRL, 1);
    read_pair(lo, hi);
    check("R6 same mode keeps low", lo, 5);
    check("R6 same mode keeps high", hi, 7);
    wr(A_CTRL, 3);
    read_pair(lo, hi);
    check("R6 chain to 3 clears", lo + hi, 0);
    wr(A_CNT_LO, 9);
    wr(A_CNT_HI, 4);
    wr(A_CTRL, 2);
    read_pair(lo, hi);
    check("R6 3 to 2 keeps low", lo, 9);
    check("R6 3 to 2 keeps high", hi, 4);

    // R9: coherent capture across a carry
    setup(0, 255, 255);
    wr(A_CNT_LO, 8'hFE);
    wr(A_CNT_HI, 8'h12);
    wr(A_CTRL, 4);
    rd(A_CNT_LO, lo);
    @(negedge clk);
    rd(A_CNT_HI, hi);
    wr(A_CTRL, 0);
    check("R9 captured low", lo, 8'hFE);
    check("R9 captured high", hi, 8'h12);

    // R7 / R8: compare sweep, channel 2 disabled, channel 3 absent
    setup(2, 9, 0);
    wr(A_CMP_EN, 4'b1011);
    for (int c = 0; c < 10; c++) begin
      wr(4'd8, c);
      wr(4'd9, (c + 5) % 10);
      wr(4'd10, c);
      wr(4'd11, c);
      wr(A_CNT_LO, 0);
      clear_mon();
      run(4, 25);
      check("R7 cmp0 pulses", c_cmp[0], cmp_hits(c, 25, 10));
      check("R7 cmp1 pulses", c_cmp[1], cmp_hits((c + 5) % 10, 25, 10));
      check("R8 disabled cmp2", c_cmp[2], 0);
      check("R8 absent cmp3", c_cmp[3], 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule